// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates the current in one winding of a full-bridge motor driver. While the bridge drives, an external comparator watches the sensed current. Once it reports that the trip level has been reached, the controller stops driving for a fixed number of clock cycles and then drives again. The comparator is ignored for a fixed number of cycles after each turn-on, so the switching spike that follows turn-on cannot end the drive phase early.

During each off period the controller picks the decay style. It uses slow decay when the target current is rising or holding. It uses mixed decay when the target is falling, or when a mode input forces mixed decay. Mixed decay runs a fast-decay interval first and a slow-decay interval after it. Every switch between two conducting states passes through one all-off cycle, which gives the bridge dead time. A single enable input is the combined condition of sleep, disable and undervoltage lockout. When it is low, the bridge is held fully off.

Top module: `chop_offtime`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any clock edge that samples `enable` low, `bridgeState` is 2'b00 (off).
- R2: After an edge that samples `enable` high while the block is off, `bridgeState` becomes 2'b01 (drive) in the next cycle.
- R3: During the first BLANK_CYC cycles of every drive phase, `tripIn` is ignored and not remembered: the bridge keeps driving, even after `tripIn` has fallen again.
- R4: A high `tripIn` sampled in drive cycle number BLANK_CYC or later (counting from 0) makes `bridgeState` 2'b00 in the next cycle. If `tripIn` first rises at drive cycle d, the drive phase lasts max(d, BLANK_CYC)+1 cycles.
- R5: When `stepFalling` and `forceMixed` are both low at the trip edge, the off window is OFF_CYC+1 cycles long and runs: 00, then 2'b11 (slow) for OFF_CYC-1 cycles, then 00.
- R6: When `stepFalling` is high at the trip edge, the off window runs: 00, then 2'b10 (fast) for FAST_CYC cycles, then 00, then 11 for OFF_CYC-FAST_CYC-2 cycles, then 00. Its total length is also OFF_CYC+1 cycles.
- R7: When `forceMixed` is high at the trip edge, the off window follows the mixed sequence of R6, whatever the level of `stepFalling`.
- R8: The cycle after the off window ends is a drive cycle, and the blanking period starts again from zero.
- R9: `bridgeState` never changes directly from one non-zero code to a different non-zero code. An all-off cycle always lies between them.
- R10: Lowering `enable` in the middle of an off window makes the output off in the next cycle. When `enable` returns, a new drive phase begins with full blanking.
- R11: The decay style is fixed at the trip edge. Changing `stepFalling` during the off window does not change that window's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | High allows switching. Low means sleep, disable or undervoltage |
| tripIn | input | 1 | Comparator output, high when the sensed current has reached the trip level |
| stepFalling | input | 1 | High when the target current is decreasing |
| forceMixed | input | 1 | High forces mixed decay |
| bridgeState | output | 2 | 00 off, 01 drive, 10 fast decay, 11 slow decay |

## Verification
The hardest situation to reach from the ports is a trip that lands exactly on the boundary of the blanking period. The stimulus gets there with a sweep. For each of the four combinations of the decay-mode inputs, the bench holds the comparator high from every drive-cycle offset between 0 and BLANK_CYC+2, and counts how many drive cycles pass before the bridge turns off. After each trip the bench flips `stepFalling` while the off window is running. It then compares every cycle of the window with the sequence computed for the decay style that was in force at the trip. It also drops `enable` partway through a window, to show that switching stops at once and that blanking starts again from zero.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DRIVE  = 2'd1,
    PH_OFFWIN = 2'd2
  } chopPhase_t;

  typedef struct packed {
    logic offClr;
    logic offInc;
    logic blankClr;
  } chopStrobe_t;

  localparam logic [1:0] BR_OFF   = 2'b00;
  localparam logic [1:0] BR_DRIVE = 2'b01;
  localparam logic [1:0] BR_FAST  = 2'b10;
  localparam logic [1:0] BR_SLOW  = 2'b11;

endpackage

// File: rtl/chop_datapath.sv
module chop_datapath
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 16,
  parameter int OFF_CYC   = 120,
  localparam int BW = $clog2(BLANK_CYC + 1),
  localparam int OW = $clog2(OFF_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chopStrobe_t   strobe,
  output logic          blankDone,
  output logic [OW-1:0] offCnt
);

  localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_CYC);
  localparam logic [OW-1:0] OFF_LAST   = OW'(OFF_CYC);

  logic [BW-1:0] blankCnt;

  // Blanking counter: restarts on each drive entry and saturates at the limit
  always_ff @(posedge clk) begin
    if (!rst_n)              blankCnt <= '0;
    else if (strobe.blankClr) blankCnt <= '0;
    else if (!blankDone)     blankCnt <= blankCnt + 1'b1;
  end

  assign blankDone = (blankCnt == BLANK_LAST);

  // Off-window cycle counter
  always_ff @(posedge clk) begin
    if (!rst_n)             offCnt <= '0;
    else if (strobe.offClr) offCnt <= '0;
    else if (strobe.offInc) offCnt <= offCnt + 1'b1;
  end

  p_off_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    offCnt <= OFF_LAST);

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int OFF_CYC  = 120,
  parameter int FAST_CYC = 40,
  localparam int OW = $clog2(OFF_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tripIn,
  input  logic          stepFalling,
  input  logic          forceMixed,
  input  logic          blankDone,
  input  logic [OW-1:0] offCnt,
  output chopStrobe_t   strobe,
  output logic [1:0]    bridgeState
);

  localparam logic [OW-1:0] OFF_LAST  = OW'(OFF_CYC);
  localparam logic [OW-1:0] FAST_LAST = OW'(FAST_CYC);
  localparam logic [OW-1:0] MID_DEAD  = OW'(FAST_CYC + 1);

  chopPhase_t ph, phNext;
  logic       mixedLat, mixedNext;

  always_comb begin
    phNext    = ph;
    mixedNext = mixedLat;
    strobe    = '0;
    unique case (ph)
      PH_IDLE: begin
        if (enable) begin
          phNext          = PH_DRIVE;
          strobe.blankClr = 1'b1;
        end
      end
      PH_DRIVE: begin
        if (tripIn && blankDone) begin
          phNext        = PH_OFFWIN;
          strobe.offClr = 1'b1;
          mixedNext     = stepFalling | forceMixed;
        end
      end
      PH_OFFWIN: begin
        if (offCnt == OFF_LAST) begin
          phNext          = PH_DRIVE;
          strobe.blankClr = 1'b1;
        end else begin
          strobe.offInc = 1'b1;
        end
      end
      default: phNext = PH_IDLE;
    endcase
    if (!enable) phNext = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      mixedLat <= 1'b0;
    end else begin
      ph       <= phNext;
      mixedLat <= mixedNext;
    end
  end

  // Bridge code from phase and off-window position; dead cycles at window edges
  always_comb begin
    bridgeState = BR_OFF;
    if (ph == PH_DRIVE) begin
      bridgeState = BR_DRIVE;
    end else if (ph == PH_OFFWIN) begin
      if (offCnt == '0 || offCnt == OFF_LAST)
        bridgeState = BR_OFF;
      else if (!mixedLat)
        bridgeState = BR_SLOW;
      else if (offCnt <= FAST_LAST)
        bridgeState = BR_FAST;
      else if (offCnt == MID_DEAD)
        bridgeState = BR_OFF;
      else
        bridgeState = BR_SLOW;
    end
  end

  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> bridgeState == BR_OFF);

  p_blank_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DRIVE && !blankDone && enable) |=> ph == PH_DRIVE);

  p_reblank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_OFFWIN && offCnt == OFF_LAST && enable) |=> (ph == PH_DRIVE && !blankDone));

  p_dead_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bridgeState != BR_OFF) |=> (bridgeState == BR_OFF || bridgeState == $past(bridgeState)));

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_OFFWIN) |=> (ph != PH_OFFWIN || $stable(mixedLat)));

endmodule

// File: rtl/chop_offtime.sv
module chop_offtime
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 16,
  parameter int OFF_CYC   = 120,
  parameter int FAST_CYC  = 40,
  localparam int OW = $clog2(OFF_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tripIn,
  input  logic       stepFalling,
  input  logic       forceMixed,
  output logic [1:0] bridgeState
);

  chopStrobe_t   strobe;
  logic          blankDone;
  logic [OW-1:0] offCnt;

  chop_ctrl #(
    .OFF_CYC (OFF_CYC),
    .FAST_CYC(FAST_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tripIn     (tripIn),
    .stepFalling(stepFalling),
    .forceMixed (forceMixed),
    .blankDone  (blankDone),
    .offCnt     (offCnt),
    .strobe     (strobe),
    .bridgeState(bridgeState)
  );

  chop_datapath #(
    .BLANK_CYC(BLANK_CYC),
    .OFF_CYC  (OFF_CYC)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .blankDone(blankDone),
    .offCnt   (offCnt)
  );

endmodule

// File: tb/sim_chop_offtime.sv
module sim_chop_offtime;

  localparam int BLANK = 3;
  localparam int OFFC  = 10;
  localparam int FASTC = 4;

  logic       clk = 1'b0;
  logic       rst_n, enable, tripIn, stepFalling, forceMixed;
  logic [1:0] bridgeState;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  chop_offtime #(
    .BLANK_CYC(BLANK),
    .OFF_CYC  (OFFC),
    .FAST_CYC (FASTC)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tripIn     (tripIn),
    .stepFalling(stepFalling),
    .forceMixed (forceMixed),
    .bridgeState(bridgeState)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expOff(int i, bit mixed);
    if (i == 0 || i == OFFC) return 0;
    if (!mixed) return 3;
    if (i <= FASTC) return 2;
    if (i == FASTC + 1) return 0;
    return 3;
  endfunction

  // Called in off-window cycle 0; checks the whole window and the return to drive
  task automatic runOff(bit mixed, bit sfAtTrip, string req);
    for (int i = 0; i <= OFFC; i++) begin
      check((expOff(i, mixed) == 0) ? "R9" : req, int'(bridgeState), expOff(i, mixed));
      if (i == 0) stepFalling = ~sfAtTrip;  // R11: late change must not matter
      tick();
    end
    stepFalling = sfAtTrip;
    check("R8", int'(bridgeState), 1);
  endtask

  // Called in drive cycle 0; holds trip high from cycle d on and counts drive cycles
  task automatic countDrive(int d, string req);
    int cnt = 0;
    while (bridgeState == 2'b01 && cnt < 60) begin
      tripIn = (cnt >= d);
      tick();
      cnt++;
    end
    tripIn = 1'b0;
    check(req, cnt, ((d > BLANK) ? d : BLANK) + 1);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; tripIn = 1'b0; stepFalling = 1'b0; forceMixed = 1'b0;
    repeat (3) tick();
    check("R1", int'(bridgeState), 0);
    rst_n = 1'b1;
    tick();
    check("R1", int'(bridgeState), 0);
    enable = 1'b1;
    tick();
    check("R2", int'(bridgeState), 1);

    // R3: trip inside blanking is masked and forgotten
    tripIn = 1'b1;
    for (int k = 0; k < BLANK; k++) begin
      tick();
      check("R3", int'(bridgeState), 1);
    end
    tripIn = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R3", int'(bridgeState), 1);
    end
    tripIn = 1'b1;
    tick();
    check("R4", int'(bridgeState), 0);
    tripIn = 1'b0;
    runOff(1'b0, 1'b0, "R5");

    // Sweep: every decay-input combination against every trip offset
    for (int combo = 0; combo < 4; combo++) begin
      for (int d = 0; d <= BLANK + 2; d++) begin
        stepFalling = combo[0];
        forceMixed  = combo[1];
        countDrive(d, "R4");
        if (combo[1])      runOff(1'b1, combo[0], "R7");
        else if (combo[0]) runOff(1'b1, combo[0], "R6");
        else               runOff(1'b0, combo[0], "R11");
      end
    end
    stepFalling = 1'b0;
    forceMixed  = 1'b0;

    // R10: disable in the middle of an off window
    countDrive(0, "R8");
    repeat (3) tick();
    enable = 1'b0;
    tick();
    check("R10", int'(bridgeState), 0);
    repeat (2) tick();
    check("R1", int'(bridgeState), 0);
    enable = 1'b1;
    tick();
    check("R10", int'(bridgeState), 1);
    countDrive(0, "R10");
    runOff(1'b0, 1'b0, "R5");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule